// File: doc/BRIEF.md
# ECC Protected Memory Path with Hardware Scrub

This block sits between a memory requester and a 72-bit memory array in which each word holds 64 data bits and 8 check bits. On a write it appends a single-error-correct, double-error-detect check byte to the data. On a read it recomputes the check bits, forms a syndrome, returns corrected data for any single flipped bit and flags words with two flipped bits as uncorrectable. Each error is reported through one-cycle strobes together with the row number of the failing address, for use by an error logger.

After every corrected read the block writes the repaired word back to the same address on its own, so that a soft error is removed from the array without a software scrub routine. While this write-back is in flight, the requester sees the ready signal low. After reset the block first sweeps the whole array, writing an all-zero word with valid check bits to every address. Requests are held off until this sweep ends, so no read ever sees check bits left undefined at power-on.

Top module: `ecc_scrub_ctrl`

## Requirements
- R1: A write accepted with `req_valid & req_ready & req_write` drives `mem_we` in the same cycle. It stores `{chk[7:0], data[63:0]}`. Data bit k takes the k-th Hamming position, counting upward from 3 and skipping powers of two. `chk[i]` for i=0..6 is the XOR of the data bits whose position has bit i set. `chk[7]` makes the XOR of all 72 bits zero.
- R2: After reset, `init_done` and `req_ready` are low. The block writes the all-zero word to addresses 0 through 2^ADDR_W-1 in ascending order, one per cycle. `init_done` then rises and stays high.
- R3: No read (`mem_re`) is issued while `init_done` is low.
- R4: An accepted read issues `mem_re` in the same cycle. On the cycle after `mem_rvalid`, `rsp_valid` pulses for one cycle with the stored data. If the word is clean, neither error strobe is raised.
- R5: If exactly one of the 72 bits read is flipped, the response carries the corrected data and `err_single` pulses together with `rsp_valid`.
- R6: In the cycle after a single-bit error is detected, the block writes the corrected data back to the read address, with freshly computed check bits. `req_ready` stays low from read acceptance until that write-back ends: two cycles after a corrected read, one cycle after any other read.
- R7: A single flipped check bit, including the overall parity bit, leaves the returned data unchanged and still causes the write-back of R6.
- R8: If exactly two bits are flipped, `err_multi` pulses with `rsp_valid`, the raw uncorrected data is returned and no write-back is issued.
- R9: `err_row` carries the upper ROW_W bits of the read address and is valid while either error strobe is high.
- R10: Read data that arrives on `mem_rvalid` while `init_done` is low produces neither a response nor an error strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DATA_W | Read data (corrected when possible) |
| err_single | output | 1 | Corrected error strobe |
| err_multi | output | 1 | Uncorrectable error strobe |
| err_row | output | ROW_W | Row of the failing read |
| init_done | output | 1 | Initialization sweep finished |
| mem_we | output | 1 | Array write enable |
| mem_re | output | 1 | Array read enable |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | DATA_W+8 | Array write word |
| mem_rdata | input | DATA_W+8 | Array read word |
| mem_rvalid | input | 1 | Array read data valid |

## Verification
The bench builds the block with DATA_W=64, ADDR_W=5 and ROW_W=2. The 32-word sweep therefore finishes in a few dozen cycles, and every write it makes can be checked against the expected address order. With only 32 addresses, four rows are visible on `err_row`. The full 72-bit codeword stays in place, so a flip can be injected at any data or check position, including the overall parity bit. Spurious read data is also delivered during the sweep to check that it is suppressed.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RDWAIT = 2'd1,
      ST_SCRUB  = 2'd2
   } ctl_state_t;

   // number of Hamming parity bits needed for dw data bits
   function automatic int par_bits(input int dw);
      int p;
      p = 1;
      for (int n = 0; n < 16; n++) begin
         if ((1 << p) < dw + p + 1) p++;
      end
      return p;
   endfunction

   // codeword position of data bit k (non-power-of-two slots from 3 up)
   function automatic int slot_of(input int k);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int p = 3; p < 2100; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == k && res == 0) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
   import ecc_scrub_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int P     = par_bits(DATA_W),
   localparam int CHK_W = P + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);

   function automatic logic [DATA_W-1:0] cover_mask(input int i);
      logic [DATA_W-1:0] m;
      for (int k = 0; k < DATA_W; k++) begin
         m[k] = ((slot_of(k) >> i) & 1) != 0;
      end
      return m;
   endfunction

   logic [P-1:0] ham;

   generate
      for (genvar i = 0; i < P; i++) begin : g_par
         localparam logic [DATA_W-1:0] MASK = cover_mask(i);
         assign ham[i] = ^(data_i & MASK);
      end
   endgenerate

   assign chk_o = {^{data_i, ham}, ham};

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
   import ecc_scrub_pkg::*;
#(
   parameter int DATA_W  = 64,
   localparam int P      = par_bits(DATA_W),
   localparam int CHK_W  = P + 1,
   localparam int WORD_W = DATA_W + CHK_W
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [DATA_W-1:0] data_o,
   output logic              single_o,
   output logic              multi_o
);

   localparam int            TOP_POS = DATA_W + P;
   localparam logic [P-1:0]  TOP     = P'(TOP_POS);

   logic [DATA_W-1:0] raw;
   logic [CHK_W-1:0]  chk;
   logic [CHK_W-1:0]  re_chk;
   logic [P-1:0]      syn;
   logic              odd;
   logic              in_range;
   logic [DATA_W-1:0] flip;

   assign raw = word_i[DATA_W-1:0];
   assign chk = word_i[WORD_W-1:DATA_W];

   ecc_encoder #(.DATA_W(DATA_W)) u_reenc (
      .data_i (raw),
      .chk_o  (re_chk)
   );

   assign syn      = chk[P-1:0] ^ re_chk[P-1:0];
   // parity of the whole stored word, rebuilt from the re-encode
   assign odd      = chk[P] ^ re_chk[P] ^ (^syn);
   assign in_range = (syn <= TOP);

   assign single_o = odd & in_range;
   assign multi_o  = (~odd & (syn != '0)) | (odd & ~in_range);

   generate
      for (genvar k = 0; k < DATA_W; k++) begin : g_fix
         localparam logic [P-1:0] POS = P'(slot_of(k));
         assign flip[k] = odd & (syn == POS);
      end
   endgenerate

   assign data_o = raw ^ flip;

endmodule

// File: rtl/ecc_init_seq.sv
module ecc_init_seq #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              busy_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] LAST = '1;

   logic [ADDR_W-1:0] cnt;
   logic              done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) done <= 1'b1;
      end
   end

   assign busy_o = ~done;
   assign addr_o = cnt;

endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
   import ecc_scrub_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int ADDR_W  = 10,
   parameter int ROW_W   = 3,
   localparam int WORD_W = DATA_W + par_bits(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              err_single,
   output logic              err_multi,
   output logic [ROW_W-1:0]  err_row,
   output logic              init_done,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_rvalid
);

   localparam int CHK_W = WORD_W - DATA_W;

   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("ecc_scrub_ctrl: DATA_W must be at least 4");
      end
      if (ROW_W < 1 || ROW_W > ADDR_W) begin : g_bad_row
         $error("ecc_scrub_ctrl: ROW_W must lie in 1..ADDR_W");
      end
   endgenerate

   ctl_state_t        state;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;
   logic              init_busy;
   logic [ADDR_W-1:0] init_addr;
   logic [DATA_W-1:0] enc_data;
   logic [CHK_W-1:0]  enc_chk;
   logic [DATA_W-1:0] dec_data;
   logic              dec_single;
   logic              dec_multi;
   logic              take_wr;
   logic              take_rd;

   ecc_init_seq #(.ADDR_W(ADDR_W)) u_init (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_o (init_busy),
      .addr_o (init_addr)
   );

   ecc_encoder #(.DATA_W(DATA_W)) u_enc (
      .data_i (enc_data),
      .chk_o  (enc_chk)
   );

   ecc_decoder #(.DATA_W(DATA_W)) u_dec (
      .word_i   (mem_rdata),
      .data_o   (dec_data),
      .single_o (dec_single),
      .multi_o  (dec_multi)
   );

   assign init_done = ~init_busy;
   assign req_ready = init_done & (state == ST_IDLE);
   assign take_wr   = req_ready & req_valid & req_write;
   assign take_rd   = req_ready & req_valid & ~req_write;

   assign mem_re = take_rd;
   assign mem_we = init_busy | take_wr | (state == ST_SCRUB);

   always_comb begin
      if (init_busy) begin
         mem_addr = init_addr;
         enc_data = '0;
      end else if (state == ST_SCRUB) begin
         mem_addr = hold_addr;
         enc_data = hold_data;
      end else begin
         mem_addr = req_addr;
         enc_data = req_wdata;
      end
   end

   assign mem_wdata = {enc_chk, enc_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         hold_addr  <= '0;
         hold_data  <= '0;
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
         err_single <= 1'b0;
         err_multi  <= 1'b0;
         err_row    <= '0;
      end else begin
         rsp_valid  <= 1'b0;
         err_single <= 1'b0;
         err_multi  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (take_rd) begin
                  hold_addr <= req_addr;
                  state     <= ST_RDWAIT;
               end
            end
            ST_RDWAIT: begin
               if (mem_rvalid) begin
                  rsp_valid  <= 1'b1;
                  rsp_data   <= dec_data;
                  err_single <= dec_single;
                  err_multi  <= dec_multi;
                  err_row    <= hold_addr[ADDR_W-1 -: ROW_W];
                  hold_data  <= dec_data;
                  state      <= dec_single ? ST_SCRUB : ST_IDLE;
               end
            end
            ST_SCRUB: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ecc_scrub_chk.sv
module ecc_scrub_chk (
   input logic clk,
   input logic rst_n,
   input logic init_done,
   input logic req_ready,
   input logic mem_re,
   input logic mem_we,
   input logic rsp_valid,
   input logic err_single,
   input logic err_multi
);

   // R3
   no_early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !mem_re);

   // R2
   init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R2
   init_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !req_ready);

   // R6
   scrub_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_single |-> (mem_we && !req_ready));

   // R8
   no_scrub_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_multi |-> req_ready);

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_single && err_multi));

   // R4
   strobe_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_single || err_multi) |-> rsp_valid);

   // R10
   no_rsp_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !rsp_valid);

endmodule

bind ecc_scrub_ctrl ecc_scrub_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .init_done  (init_done),
   .req_ready  (req_ready),
   .mem_re     (mem_re),
   .mem_we     (mem_we),
   .rsp_valid  (rsp_valid),
   .err_single (err_single),
   .err_multi  (err_multi)
);

// File: tb/sim_ecc_scrub_ctrl.sv
`timescale 1ns/1ps
module sim_ecc_scrub_ctrl;

   localparam int DW = 64;
   localparam int AW = 5;
   localparam int RW = 2;
   localparam int WW = 72;
   localparam int DEPTH = 1 << AW;

   typedef struct packed {
      logic [DW-1:0] d;
      logic          s;
      logic          m;
      logic [RW-1:0] row;
      logic [3:0]    rq;
   } rsp_t;

   typedef struct packed {
      logic [AW-1:0] a;
      logic [WW-1:0] w;
   } scr_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, err_single, err_multi, init_done;
   logic [DW-1:0] rsp_data;
   logic [RW-1:0] err_row;
   logic mem_we, mem_re;
   logic [AW-1:0] mem_addr;
   logic [WW-1:0] mem_wdata;
   logic [WW-1:0] mem_rdata = 72'h5;
   logic mem_rvalid = 1'b0;

   logic [WW-1:0] mem_model [DEPTH];
   logic [AW-1:0] inj_addr = '0;
   logic [WW-1:0] inj_mask = '0;
   logic spur = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int init_writes = 0;
   int early_re = 0;
   int unexpected = 0;
   int stall = 0;
   bit finished = 0;

   rsp_t rsp_q[$];
   scr_t scr_q[$];

   always #5 clk = ~clk;

   ecc_scrub_ctrl #(.DATA_W(DW), .ADDR_W(AW), .ROW_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .err_single(err_single), .err_multi(err_multi), .err_row(err_row),
      .init_done(init_done),
      .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
   );

   // array model: one-cycle registered read with a fault-injection mask
   always @(posedge clk) begin
      if (mem_we) mem_model[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem_model[mem_addr] ^ ((mem_addr == inj_addr) ? inj_mask : '0);
      mem_rvalid <= mem_re | spur;
   end

   // reference encoder, built position by position
   function automatic logic [WW-1:0] ref_enc(input logic [DW-1:0] d);
      logic [71:0] cw;
      logic [7:0]  c;
      int k;
      cw = '0;
      c  = '0;
      k  = 0;
      for (int pos = 1; pos < 72; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            cw[pos] = d[k];
            k++;
         end
      end
      for (int i = 0; i < 7; i++) begin
         for (int pos = 1; pos < 72; pos++) begin
            if (((pos >> i) & 1) != 0 && (pos & (pos - 1)) != 0) c[i] = c[i] ^ cw[pos];
         end
      end
      c[7] = ^{c[6:0], d};
      return {c, d};
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (!init_done && mem_we) begin
            // R2: sweep order and zero word
            check(mem_addr == AW'(init_writes) && mem_wdata == '0, "R2", "init write",
                  {mem_addr, mem_wdata[66:0]}, {AW'(init_writes), 67'h0});
            init_writes++;
         end
         if (!init_done && mem_re) early_re++;
         if (rsp_valid) begin
            if (!init_done) unexpected++;
            else if (rsp_q.size() == 0) begin
               check(0, "R8", "response with nothing queued", {8'h0, rsp_data}, '0);
            end else begin
               rsp_t e;
               e = rsp_q.pop_front();
               check(rsp_data == e.d, $sformatf("R%0d", e.rq), "rsp_data", {8'h0, rsp_data}, {8'h0, e.d});
               check(err_single == e.s && err_multi == e.m, $sformatf("R%0d", e.rq), "strobes",
                     {70'h0, err_single, err_multi}, {70'h0, e.s, e.m});
               if (e.s || e.m)
                  // R9: row of failing access
                  check(err_row == e.row, "R9", "err_row", {70'h0, err_row}, {70'h0, e.row});
            end
         end
         if (init_done && mem_we && !req_ready) begin
            if (scr_q.size() == 0) begin
               // R8: write-back after uncorrectable error is a failure
               check(0, "R8", "unexpected scrub write", mem_wdata, '0);
            end else begin
               scr_t s;
               s = scr_q.pop_front();
               // R6
               check(mem_addr == s.a && mem_wdata == s.w, "R6", "scrub write",
                     mem_wdata ^ {67'h0, mem_addr}, s.w ^ {67'h0, s.a});
            end
         end
      end
   end

   task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      stall = 0;
      while (!req_ready) begin
         stall++;
         @(negedge clk);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      issue(1'b1, a, d);
      // R1
      check(mem_model[a] == ref_enc(d), "R1", "stored codeword", mem_model[a], ref_enc(d));
   endtask

   // kind: 0 clean, 1 single, 2 double
   task automatic do_read(input logic [AW-1:0] a, input logic [WW-1:0] mask,
                          input int kind, input logic [3:0] rq);
      logic [WW-1:0] st;
      rsp_t e;
      scr_t s;
      st = mem_model[a];
      e.d   = (kind == 2) ? (st[DW-1:0] ^ mask[DW-1:0]) : st[DW-1:0];
      e.s   = (kind == 1);
      e.m   = (kind == 2);
      e.row = a[AW-1 -: RW];
      e.rq  = rq;
      rsp_q.push_back(e);
      if (kind == 1) begin
         s.a = a;
         s.w = ref_enc(st[DW-1:0]);
         scr_q.push_back(s);
      end
      inj_addr = a;
      inj_mask = mask;
      issue(1'b0, a, '0);
      inj_mask = '0;
      // R6: stall length tells whether a write-back ran
      check(stall == ((kind == 1) ? 2 : 1), "R6", "ready-low cycles",
            WW'(stall), WW'((kind == 1) ? 2 : 1));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      check(!init_done && !req_ready && !rsp_valid, "R2", "reset state",
            {69'h0, init_done, req_ready, rsp_valid}, '0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      spur = 1'b1;
      repeat (3) @(negedge clk);
      spur = 1'b0;
      while (!init_done) @(negedge clk);
      check(init_writes == DEPTH, "R2", "init write count", WW'(init_writes), WW'(DEPTH));
      check(unexpected == 0, "R10", "response during init", WW'(unexpected), '0);
      check(early_re == 0, "R3", "read during init", WW'(early_re), '0);

      do_write(5'd0,  64'hDEAD_BEEF_0123_4567);
      do_write(5'd5,  64'hFFFF_FFFF_FFFF_FFFF);
      do_write(5'd9,  64'hAAAA_5555_AAAA_5555);
      do_write(5'd17, 64'h0000_0001_8000_0000);
      do_write(5'd26, 64'h1357_9BDF_2468_ACE0);
      do_write(5'd31, 64'h8000_0000_0000_0001);

      // R4: clean reads
      do_read(5'd0,  '0, 0, 4'd4);
      do_read(5'd5,  '0, 0, 4'd4);
      do_read(5'd31, '0, 0, 4'd4);
      do_read(5'd12, '0, 0, 4'd4);
      // R5: single data-bit flips
      do_read(5'd9,  72'h1 << 0,  1, 4'd5);
      do_read(5'd17, 72'h1 << 37, 1, 4'd5);
      do_read(5'd26, 72'h1 << 63, 1, 4'd5);
      // R7: single check-bit flips, overall parity included
      do_read(5'd0,  72'h1 << 64, 1, 4'd7);
      do_read(5'd31, 72'h1 << 71, 1, 4'd7);
      do_read(5'd5,  72'h1 << 68, 1, 4'd7);
      // R8: double flips
      do_read(5'd9,  (72'h1 << 3) | (72'h1 << 40), 2, 4'd8);
      do_read(5'd26, (72'h1 << 64) | (72'h1 << 10), 2, 4'd8);
      // write directly after a scrubbed read
      do_read(5'd17, 72'h1 << 12, 1, 4'd5);
      do_write(5'd17, 64'h0F0F_0F0F_F0F0_F0F0);
      do_read(5'd17, '0, 0, 4'd4);

      repeat (5) @(negedge clk);
      check(rsp_q.size() == 0, "R4", "responses outstanding", WW'(rsp_q.size()), '0);
      check(scr_q.size() == 0, "R6", "write-backs missing", WW'(scr_q.size()), '0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule